// File: doc/BRIEF.md
# Exception Entry and Dispatch Unit

This unit sits next to a simple processor's program counter and decides when control leaves the running program for a handler. Each cycle it looks at three kinds of request: a synchronous event raised by the current instruction, which carries a class and an 8-bit exception number; a non-maskable interrupt line; and a maskable interrupt request that brings its own vector. It picks at most one of them. It then issues a redirect to the handler address, which it forms from a programmable table base and the exception number. It also records the return point that the class calls for, moves the processor into kernel mode and turns maskable interrupts off.

A return-from-interrupt strobe reverses an entry. It sends the PC back to the saved return point and restores the previous mode and the previous interrupt-enable value. There is one level of saved context. A handler that takes a further exception overwrites it. An abort sends the processor to its handler but never creates a return point, and it raises a sticky fatal flag.

All outputs are registered. A request sampled at one rising edge shows its redirect, mode change and saved state right after that edge.

Top module: `exc_unit`

## Requirements
- R1: After reset the unit is in kernel mode (kernel_mode=1) with int_en=0, redirect_valid=0, intr_ack=0 and fatal=0. The saved context is PC 0, user mode and interrupts enabled, so a return-from-interrupt issued straight after reset goes to address 0 in user mode with int_en=1.
- R2: Every entry redirects, one cycle after the request is sampled, to table base + 4 × exception number. The table base is written through base_we/base_wdata and is used from the next cycle on.
- R3: sync_class encodes 0 = trap, 1 = fault, 2 = abort, 3 = fault. A trap saves next_pc as the return point. A fault, including class 3, saves instr_pc.
- R4: An abort (class 2) redirects to its handler and sets fatal, which stays set until reset. It leaves the saved return PC, saved mode and saved enable unchanged.
- R5: Any entry sets kernel_mode=1 and int_en=0. Every entry except an abort saves the mode and enable value that were in force before it.
- R6: A return-from-interrupt (rti) redirects to the saved PC and restores the saved mode and enable value. It is ignored in any cycle in which an exception is taken.
- R7: A maskable interrupt is taken only while int_en=1 and at_boundary=1. Its number is intr_vector and it saves next_pc. intr_ack pulses for exactly one cycle, together with the redirect. The ie_we/ie_wdata write sets int_en from the next cycle, in cycles where no entry or return happens.
- R8: A rising edge on nmi_req is latched and taken at an instruction boundary whatever the value of int_en. It always uses exception number 2 and saves next_pc.
- R9: When several requests arrive together, the order is: a synchronous event (abort, fault or trap) first, then the NMI, then the maskable interrupt. A losing NMI stays pending.
- R10: An NMI edge that arrives while an NMI handler is running (between NMI entry and the next rti) is held. It is taken at the first boundary after that rti.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the instruction that follows it |
| at_boundary | input | 1 | The current instruction is complete; interrupts may be taken |
| sync_valid | input | 1 | The current instruction raises a synchronous exception |
| sync_class | input | 2 | Class of the synchronous exception |
| sync_num | input | 8 | Exception number of the synchronous exception |
| nmi_req | input | 1 | Non-maskable interrupt line (edge sensitive) |
| intr_req | input | 1 | Maskable interrupt request (level) |
| intr_vector | input | 8 | Exception number supplied with the maskable request |
| rti | input | 1 | Return-from-interrupt strobe |
| base_we | input | 1 | Write strobe for the table base |
| base_wdata | input | 32 | New table base value |
| ie_we | input | 1 | Write strobe for the interrupt-enable flag |
| ie_wdata | input | 1 | New interrupt-enable value |
| redirect_valid | output | 1 | The PC must load redirect_pc |
| redirect_pc | output | 32 | Handler address or return address |
| kernel_mode | output | 1 | 1 = kernel, 0 = user |
| int_en | output | 1 | Maskable interrupts enabled |
| saved_pc | output | 32 | Saved return point |
| cause_num | output | 8 | Number of the last exception taken |
| intr_ack | output | 1 | One-cycle acknowledge of a maskable interrupt |
| fatal | output | 1 | Sticky: an abort has been taken |

## Verification
The assertions check several rules on every cycle:
- every entry leaves kernel mode set and interrupts off;
- an NMI entry reports number 2;
- an acknowledge only follows a cycle with interrupts enabled;
- an abort leaves the saved PC untouched and sets fatal;
- no NMI is granted while an NMI handler is active.

Other behaviour can only be shown by the bench's scenarios, because it depends on the arithmetic and on the order of requests:
- the handler addresses, swept over all 256 numbers for traps and faults under two different bases;
- the return point chosen by each class;
- the restore done by a return;
- masking and boundary gating;
- the priority order when requests collide;
- the deferral of a second NMI until after the return.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        CLS_TRAP  = 2'd0,
        CLS_FAULT = 2'd1,
        CLS_ABORT = 2'd2,
        CLS_FLT2  = 2'd3
    } exc_class_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_ABORT = 3'd1,
        SRC_SYNC  = 3'd2,
        SRC_NMI   = 3'd3,
        SRC_INTR  = 3'd4
    } exc_src_e;

endpackage

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
(
    input  logic       sync_valid,
    input  logic [1:0] sync_class,
    input  logic       nmi_avail,
    input  logic       nmi_active,
    input  logic       at_boundary,
    input  logic       int_en,
    input  logic       intr_req,
    output logic       g_abort,
    output logic       g_sync,
    output logic       g_nmi,
    output logic       g_intr,
    output exc_src_e   src
);
    logic is_abort;

    always_comb begin
        is_abort = (sync_class == CLS_ABORT);
        g_abort  = sync_valid && is_abort;
        g_sync   = sync_valid && !is_abort;
        g_nmi    = !sync_valid && at_boundary && nmi_avail && !nmi_active;
        g_intr   = !sync_valid && !g_nmi && at_boundary && int_en && intr_req;
        if (g_abort)     src = SRC_ABORT;
        else if (g_sync) src = SRC_SYNC;
        else if (g_nmi)  src = SRC_NMI;
        else if (g_intr) src = SRC_INTR;
        else             src = SRC_NONE;
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int AW          = 32,
    parameter int NW          = 8,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic [NW-1:0] num,
    output logic [AW-1:0] addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);
    localparam bit POW2  = ((1 << SHIFT) == ENTRY_BYTES);

    logic [AW-1:0] idx;
    assign idx = AW'(num);

    generate
        if (POW2) begin : g_shift
            assign addr = base + (idx << SHIFT);
        end else begin : g_mul
            assign addr = base + idx * AW'(ENTRY_BYTES);
        end
    endgenerate
endmodule

// File: rtl/exc_unit.sv
module exc_unit
    import exc_pkg::*;
#(
    parameter int AW          = 32,
    parameter int NW          = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int NMI_NUM     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] instr_pc,
    input  logic [AW-1:0] next_pc,
    input  logic          at_boundary,
    input  logic          sync_valid,
    input  logic [1:0]    sync_class,
    input  logic [NW-1:0] sync_num,
    input  logic          nmi_req,
    input  logic          intr_req,
    input  logic [NW-1:0] intr_vector,
    input  logic          rti,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          ie_we,
    input  logic          ie_wdata,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic          kernel_mode,
    output logic          int_en,
    output logic [AW-1:0] saved_pc,
    output logic [NW-1:0] cause_num,
    output logic          intr_ack,
    output logic          fatal
);
    localparam logic [NW-1:0] NMI_CODE = NW'(NMI_NUM);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] epc;
        logic [AW-1:0] redir_pc;
        logic [NW-1:0] cause;
        logic          redir_v;
        logic          kernel;
        logic          ie;
        logic          saved_kernel;
        logic          saved_ie;
        logic          fatal;
        logic          nmi_active;
        logic          nmi_pend;
        logic          nmi_prev;
        logic          ack;
    } state_t;

    state_t s_d, s_q;

    logic          nmi_edge;
    logic          g_abort, g_sync, g_nmi, g_intr, take;
    exc_src_e      src;
    logic [NW-1:0] sel_num;
    logic [AW-1:0] handler_pc;
    logic [AW-1:0] ret_pc;

    assign nmi_edge = nmi_req && !s_q.nmi_prev;

    exc_select u_sel (
        .sync_valid  (sync_valid),
        .sync_class  (sync_class),
        .nmi_avail   (s_q.nmi_pend || nmi_edge),
        .nmi_active  (s_q.nmi_active),
        .at_boundary (at_boundary),
        .int_en      (s_q.ie),
        .intr_req    (intr_req),
        .g_abort     (g_abort),
        .g_sync      (g_sync),
        .g_nmi       (g_nmi),
        .g_intr      (g_intr),
        .src         (src)
    );

    always_comb begin
        unique case (src)
            SRC_ABORT, SRC_SYNC: sel_num = sync_num;
            SRC_NMI:             sel_num = NMI_CODE;
            SRC_INTR:            sel_num = intr_vector;
            default:             sel_num = '0;
        endcase
    end

    exc_vector #(
        .AW          (AW),
        .NW          (NW),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_vec (
        .base (s_q.base),
        .num  (sel_num),
        .addr (handler_pc)
    );

    assign take   = (src != SRC_NONE);
    assign ret_pc = (g_sync && sync_class != CLS_TRAP) ? instr_pc : next_pc;

    always_comb begin
        s_d          = s_q;
        s_d.redir_v  = 1'b0;
        s_d.ack      = 1'b0;
        s_d.nmi_prev = nmi_req;
        s_d.nmi_pend = (s_q.nmi_pend || nmi_edge) && !g_nmi;
        if (base_we) s_d.base = base_wdata;

        if (take) begin
            s_d.redir_v  = 1'b1;
            s_d.redir_pc = handler_pc;
            s_d.cause    = sel_num;
            s_d.kernel   = 1'b1;
            s_d.ie       = 1'b0;
            if (g_abort) begin
                s_d.fatal = 1'b1;
            end else begin
                s_d.epc          = ret_pc;
                s_d.saved_kernel = s_q.kernel;
                s_d.saved_ie     = s_q.ie;
            end
            if (g_nmi)  s_d.nmi_active = 1'b1;
            if (g_intr) s_d.ack        = 1'b1;
        end else if (rti) begin
            s_d.redir_v    = 1'b1;
            s_d.redir_pc   = s_q.epc;
            s_d.kernel     = s_q.saved_kernel;
            s_d.ie         = s_q.saved_ie;
            s_d.nmi_active = 1'b0;
        end else if (ie_we) begin
            s_d.ie = ie_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q              <= '0;
            s_q.kernel       <= 1'b1;
            s_q.saved_ie     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign redirect_valid = s_q.redir_v;
    assign redirect_pc    = s_q.redir_pc;
    assign kernel_mode    = s_q.kernel;
    assign int_en         = s_q.ie;
    assign saved_pc       = s_q.epc;
    assign cause_num      = s_q.cause;
    assign intr_ack       = s_q.ack;
    assign fatal          = s_q.fatal;

    assert_entry_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (kernel_mode && !int_en && redirect_valid));

    assert_nmi_number_R8: assert property (@(posedge clk) disable iff (!rst_n)
        g_nmi |=> (cause_num == NMI_CODE));

    assert_ack_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        g_intr |-> s_q.ie);

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack |=> !intr_ack);

    assert_abort_no_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        g_abort |=> (fatal && $stable(saved_pc)));

    assert_nmi_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.nmi_active |-> !g_nmi);

    assert_fatal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
endmodule

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr_pc, next_pc, base_wdata;
    logic        at_boundary, sync_valid, nmi_req, intr_req, rti, base_we, ie_we, ie_wdata;
    logic [1:0]  sync_class;
    logic [7:0]  sync_num, intr_vector;
    logic        redirect_valid, kernel_mode, int_en, intr_ack, fatal;
    logic [31:0] redirect_pc, saved_pc;
    logic [7:0]  cause_num;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_pc(instr_pc), .next_pc(next_pc),
        .at_boundary(at_boundary), .sync_valid(sync_valid), .sync_class(sync_class),
        .sync_num(sync_num), .nmi_req(nmi_req), .intr_req(intr_req),
        .intr_vector(intr_vector), .rti(rti), .base_we(base_we), .base_wdata(base_wdata),
        .ie_we(ie_we), .ie_wdata(ie_wdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .kernel_mode(kernel_mode), .int_en(int_en),
        .saved_pc(saved_pc), .cause_num(cause_num), .intr_ack(intr_ack), .fatal(fatal)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_sync(input logic [1:0] cls, input logic [7:0] n,
                           input logic [31:0] ipc, input logic [31:0] npc);
        sync_valid = 1'b1; sync_class = cls; sync_num = n; instr_pc = ipc; next_pc = npc;
        cyc();
        sync_valid = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1;
        cyc();
        rti = 1'b0;
    endtask

    task automatic set_ie(input logic v);
        ie_we = 1'b1; ie_wdata = v;
        cyc();
        ie_we = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        base_we = 1'b1; base_wdata = b;
        cyc();
        base_we = 1'b0;
    endtask

    task automatic check_entry(input string req, input logic [31:0] base, input logic [7:0] n,
                               input logic [31:0] sv);
        chk(redirect_valid == 1'b1, {req, " redirect"}, 32'(redirect_valid), 32'd1);
        chk(redirect_pc == base + 32'(n) * 4, {req, " handler R2"}, redirect_pc, base + 32'(n) * 4);
        chk(cause_num == n, {req, " cause"}, 32'(cause_num), 32'(n));
        chk(saved_pc == sv, {req, " saved_pc"}, saved_pc, sv);
        chk(kernel_mode && !int_en, {req, " kernel/ie R5"}, {30'd0, kernel_mode, int_en}, 32'd2);
    endtask

    task automatic check_quiet(input string req);
        chk(!redirect_valid && !intr_ack, {req, " no entry"}, {30'd0, redirect_valid, intr_ack}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] b1, b2, ipc;
        rst_n = 1'b0; instr_pc = '0; next_pc = '0; at_boundary = 1'b0; sync_valid = 1'b0;
        sync_class = '0; sync_num = '0; nmi_req = 1'b0; intr_req = 1'b0; intr_vector = '0;
        rti = 1'b0; base_we = 1'b0; base_wdata = '0; ie_we = 1'b0; ie_wdata = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk(kernel_mode == 1'b1, "R1 kernel", 32'(kernel_mode), 32'd1);
        chk(int_en == 1'b0, "R1 int_en", 32'(int_en), 32'd0);
        chk(!redirect_valid && !intr_ack && !fatal, "R1 outputs", {29'd0, redirect_valid, intr_ack, fatal}, 32'd0);
        // R1 / R6 return from reset context
        do_rti();
        chk(redirect_valid && redirect_pc == 32'd0, "R1 R6 rti pc", redirect_pc, 32'd0);
        chk(!kernel_mode && int_en, "R1 R6 rti mode", {30'd0, kernel_mode, int_en}, 32'd1);

        // R2 R3 trap sweep
        b1 = 32'h0001_0000;
        set_base(b1);
        for (int n = 0; n < 256; n++) begin
            ipc = 32'h4000 + 32'(n) * 8;
            do_sync(2'd0, 8'(n), ipc, ipc + 4);
            check_entry("R3 trap", b1, 8'(n), ipc + 4);
            do_rti();
            chk(redirect_valid && redirect_pc == ipc + 4, "R6 trap return", redirect_pc, ipc + 4);
            chk(!kernel_mode && int_en, "R6 restore", {30'd0, kernel_mode, int_en}, 32'd1);
        end

        // R2 R3 fault sweep with a new base, classes 1 and 3
        b2 = 32'h8000_0400;
        set_base(b2);
        for (int n = 0; n < 256; n++) begin
            ipc = 32'h2_0000 + 32'(n) * 4;
            do_sync((n % 2 == 1) ? 2'd3 : 2'd1, 8'(n), ipc, ipc + 4);
            check_entry("R3 fault", b2, 8'(n), ipc);
            do_rti();
            chk(redirect_valid && redirect_pc == ipc, "R6 fault retry", redirect_pc, ipc);
        end

        // R7 masking and boundary gating
        set_ie(1'b0);
        chk(int_en == 1'b0, "R7 ie write", 32'(int_en), 32'd0);
        intr_req = 1'b1; intr_vector = 8'h40; at_boundary = 1'b1;
        for (int k = 0; k < 3; k++) begin cyc(); check_quiet("R7 masked"); end
        at_boundary = 1'b0;
        set_ie(1'b1);
        check_quiet("R7 ie write cycle");
        cyc();
        check_quiet("R7 no boundary");
        instr_pc = 32'h500; next_pc = 32'h504; at_boundary = 1'b1;
        cyc();
        check_entry("R7 intr", b2, 8'h40, 32'h504);
        chk(intr_ack == 1'b1, "R7 ack", 32'(intr_ack), 32'd1);
        intr_req = 1'b0;
        cyc();
        chk(intr_ack == 1'b0, "R7 ack pulse", 32'(intr_ack), 32'd0);
        do_rti();
        chk(redirect_pc == 32'h504 && int_en, "R7 return", redirect_pc, 32'h504);

        // R8 NMI ignores enable, waits for boundary
        set_ie(1'b0);
        at_boundary = 1'b0; nmi_req = 1'b1;
        cyc();
        check_quiet("R8 nmi no boundary");
        nmi_req = 1'b0; at_boundary = 1'b1; next_pc = 32'h604;
        cyc();
        check_entry("R8 nmi", b2, 8'd2, 32'h604);
        // R10 second NMI during handler is held
        nmi_req = 1'b1; next_pc = 32'h704;
        cyc();
        check_quiet("R10 nmi held");
        nmi_req = 1'b0;
        cyc();
        check_quiet("R10 nmi still held");
        do_rti();
        chk(redirect_pc == 32'h604 && !kernel_mode && !int_en, "R10 rti first", redirect_pc, 32'h604);
        cyc();
        check_entry("R10 held nmi taken", b2, 8'd2, 32'h704);
        do_rti();
        chk(redirect_pc == 32'h704 && !kernel_mode, "R10 rti second", redirect_pc, 32'h704);

        // R9 sync beats NMI beats maskable
        set_ie(1'b1);
        nmi_req = 1'b1; intr_req = 1'b1; intr_vector = 8'h41;
        do_sync(2'd0, 8'h33, 32'h800, 32'h804);
        check_entry("R9 sync wins", b2, 8'h33, 32'h804);
        chk(intr_ack == 1'b0, "R9 no ack", 32'(intr_ack), 32'd0);
        nmi_req = 1'b0; next_pc = 32'h904;
        cyc();
        check_entry("R9 pending nmi next", b2, 8'd2, 32'h904);
        intr_req = 1'b0;
        do_rti();
        chk(redirect_pc == 32'h904 && kernel_mode && !int_en, "R9 rti to handler", redirect_pc, 32'h904);
        do_rti();
        chk(redirect_pc == 32'h904 && kernel_mode, "R6 repeat rti", redirect_pc, 32'h904);
        set_ie(1'b1);
        nmi_req = 1'b1; intr_req = 1'b1; next_pc = 32'hA04;
        cyc();
        check_entry("R9 nmi over intr", b2, 8'd2, 32'hA04);
        chk(intr_ack == 1'b0, "R9 intr lost", 32'(intr_ack), 32'd0);
        nmi_req = 1'b0;
        cyc();
        check_quiet("R9 intr masked in handler");
        intr_req = 1'b0;
        do_rti();

        // R6 event beats rti
        rti = 1'b1;
        do_sync(2'd0, 8'd5, 32'hB00, 32'hB04);
        rti = 1'b0;
        check_entry("R6 event over rti", b2, 8'd5, 32'hB04);

        // R4 abort
        chk(fatal == 1'b0, "R4 fatal before", 32'(fatal), 32'd0);
        do_sync(2'd2, 8'h12, 32'hC00, 32'hC04);
        check_entry("R4 abort", b2, 8'h12, 32'hB04);
        chk(fatal == 1'b1, "R4 fatal", 32'(fatal), 32'd1);
        cyc();
        chk(fatal == 1'b1, "R4 fatal sticky", 32'(fatal), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule